// File: doc/BRIEF.md
# Accumulator File In-Place Shifter

This block keeps a small file of four 64-bit accumulators, each made of a HI register and a LO register. It carries out one operation on that file: a logical shift of a chosen accumulator, with the result written back into the same accumulator. The operation names the accumulator with a 2-bit index and gives a 6-bit two's-complement shift amount. The sign of the amount picks the direction. A non-negative amount shifts right by 0 to 31 places. A negative amount shifts left by 1 to 32 places.

The shift works on the 64-bit value formed from the low 32 bits of HI (upper half) and the low 32 bits of LO (lower half). When the result is written back, each 32-bit half is sign-extended into its 64-bit register. HI takes its sign from result bit 63 and LO takes its sign from result bit 31.

A unit-enable input guards the operation. If an operation arrives while the enable is low, nothing is written and a one-cycle fault pulse is raised instead. A load port stands in for the multiply-accumulate writeback that fills the file in a full core. A combinational read port returns both registers of any accumulator.

Top module: `acc_shift_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight 64-bit registers are cleared to zero and `fault` is cleared. After reset, every read returns zero and `fault` reads 0.
- R2: If `op_amt[5]` is 0, the 64-bit source {HI[31:0], LO[31:0]} of the selected accumulator is shifted right logically by `op_amt` (0 to 31) places, with zeros filling the vacated upper bits.
- R3: If `op_amt[5]` is 1, the source is shifted left logically by the magnitude of the two's-complement amount (1 to 32 places), with zeros filling the vacated lower bits. The amount 6'b100000 shifts by 32.
- R4: An amount of zero leaves bits [31:0] of HI and of LO unchanged.
- R5: After a shift, HI holds result[63:32] in bits [31:0], and bits [63:32] are all copies of result bit 63. Bits [63:32] of HI as they stood before the shift have no effect.
- R6: After a shift, LO holds result[31:0] in bits [31:0], and bits [63:32] are all copies of result bit 31.
- R7: The result is written on the rising edge where `op_valid` and `dsp_en` are both high. Only the accumulator named by `op_acc` changes.
- R8: If `op_valid` is high while `dsp_en` is low, no register changes. `fault` is 1 during the cycle after that edge only, and `fault` is 0 after any other cycle.
- R9: With `op_valid` and `ld_en` both low, no register changes.
- R10: `rd_hi` and `rd_lo` show, combinationally, the stored registers of the accumulator named by `rd_acc`.
- R11: If `ld_en` is high and no shift writes the same accumulator, `ld_hi` and `ld_lo` are stored unchanged into accumulator `ld_acc` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Shift operation strobe |
| op_acc | input | 2 | Accumulator to shift |
| op_amt | input | 6 | Signed shift amount (bit 5 = sign) |
| dsp_en | input | 1 | Unit enable; low turns an operation into a fault |
| ld_en | input | 1 | Load strobe for the accumulator file |
| ld_acc | input | 2 | Accumulator to load |
| ld_hi | input | 64 | Value to load into HI |
| ld_lo | input | 64 | Value to load into LO |
| rd_acc | input | 2 | Accumulator to read |
| rd_hi | output | 64 | HI register of the read accumulator |
| rd_lo | output | 64 | LO register of the read accumulator |
| fault | output | 1 | Disabled-unit fault pulse |

## Verification
The bench goes after the ends of both shift ranges: right by 31, left by 1, and left by the full 32. A design that read the amount as unsigned, or that dropped the top magnitude bit, would there shift the wrong way or leave the value in place. It loads HI values whose upper 32 bits disagree with bit 31. A design that shifted the full 64-bit register instead of the low halves would then carry garbage into the result. It also loads patterns with bit 63 and bit 31 set. A design that sign-extended LO from bit 63, or from nothing, would then show a wrong upper word. After each operation it reads all four accumulators. Disabled operations must leave every register untouched and pulse `fault` for exactly one cycle. A stray write or a fault that stays high is caught there.

// File: rtl/acc_shift_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the register pair type of the accumulator file.
// Assumes one HI and one LO register per accumulator, each twice the half width.
package acc_shift_pkg;
    localparam int HALF_W  = 32;
    localparam int REG_W   = 2 * HALF_W;
    localparam int NUM_ACC = 4;
    localparam int IDX_W   = $clog2(NUM_ACC);
    localparam int AMT_W   = $clog2(HALF_W) + 1;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } acc_pair_t;
endpackage

// File: rtl/acc_amt_decode.sv
`timescale 1ns/1ps
// Module: acc_amt_decode
// Splits a two's-complement shift amount into a direction and a magnitude.
// Assumes the most negative code means a magnitude of 2**(AMT_W-1), which
// fits in AMT_W unsigned bits.
module acc_amt_decode #(
    parameter int AMT_W = 6
) (
    input  logic [AMT_W-1:0] amt,
    output logic             dir_left,
    output logic [AMT_W-1:0] mag
);
    // Sign bit selects direction; negative codes are negated to their size.
    always_comb begin
        dir_left = amt[AMT_W-1];
        mag      = dir_left ? (~amt + AMT_W'(1)) : amt;
    end
endmodule

// File: rtl/acc_barrel.sv
`timescale 1ns/1ps
// Module: acc_barrel
// Logical shifter in both directions built from one left-shifting log stage
// chain. A right shift is done by reversing the bits before and after the
// chain. Assumes mag is below 2**SH_W and does not exceed W.
module acc_barrel #(
    parameter int W    = 64,
    parameter int SH_W = 6
) (
    input  logic [W-1:0]    din,
    input  logic            dir_left,
    input  logic [SH_W-1:0] mag,
    output logic [W-1:0]    dout
);
    logic [W-1:0] din_rev;
    logic [W-1:0] pre;
    logic [W-1:0] post_rev;
    logic [W-1:0] stage [SH_W+1];

    // Bit reversal of the input, used for right shifts.
    for (genvar b = 0; b < W; b++) begin : g_rev_in
        assign din_rev[b] = din[W-1-b];
    end

    // Pick the natural or reversed operand for the chain.
    always_comb pre = dir_left ? din : din_rev;

    assign stage[0] = pre;

    // One stage per magnitude bit, each shifting by its power of two.
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        always_comb stage[s+1] = mag[s] ? (stage[s] << STEP) : stage[s];
    end

    // Undo the reversal of the chain output.
    for (genvar b = 0; b < W; b++) begin : g_rev_out
        assign post_rev[b] = stage[SH_W][W-1-b];
    end

    // Choose the output orientation that matches the direction.
    always_comb dout = dir_left ? stage[SH_W] : post_rev;
endmodule

// File: rtl/acc_regfile.sv
`timescale 1ns/1ps
// Module: acc_regfile
// Holds NUM pairs of W-bit HI/LO registers. It has one shift write port, one
// load port, one read port for the shift source and one general read port.
// The shift write wins over a load to the same entry. Assumes a synchronous
// active-low reset.
module acc_regfile #(
    parameter int NUM = 4,
    parameter int W   = 64,
    localparam int IW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sh_we,
    input  logic [IW-1:0] sh_idx,
    input  logic [W-1:0]  sh_hi,
    input  logic [W-1:0]  sh_lo,
    input  logic          ld_we,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_hi,
    input  logic [W-1:0]  ld_lo,
    input  logic [IW-1:0] src_idx,
    output logic [W-1:0]  src_hi,
    output logic [W-1:0]  src_lo,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_hi,
    output logic [W-1:0]  rd_lo
);
    logic [W-1:0] hi_q [NUM];
    logic [W-1:0] lo_q [NUM];

    // One register pair per accumulator.
    for (genvar g = 0; g < NUM; g++) begin : g_entry
        logic hit_sh;
        logic hit_ld;
        assign hit_sh = sh_we && (sh_idx == IW'(g));
        assign hit_ld = ld_we && (ld_idx == IW'(g));

        // Reset clears the pair; otherwise a shift write, else a load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q[g] <= '0;
                lo_q[g] <= '0;
            end else if (hit_sh) begin
                hi_q[g] <= sh_hi;
                lo_q[g] <= sh_lo;
            end else if (hit_ld) begin
                hi_q[g] <= ld_hi;
                lo_q[g] <= ld_lo;
            end
        end
    end

    // Combinational read of the shift source and the general read port.
    always_comb begin
        src_hi = hi_q[src_idx];
        src_lo = lo_q[src_idx];
        rd_hi  = hi_q[rd_idx];
        rd_lo  = lo_q[rd_idx];
    end
endmodule

// File: rtl/acc_shift_top.sv
`timescale 1ns/1ps
// Module: acc_shift_top
// Shifts one accumulator of the file in place. The source is the low halves
// of HI and LO. The result halves are sign-extended back into the 64-bit
// registers on the edge after the strobe. With the unit disabled, the
// operation raises a one-cycle fault instead of writing. Assumes
// synchronous active-low reset.
module acc_shift_top
    import acc_shift_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [IDX_W-1:0] op_acc,
    input  logic [AMT_W-1:0] op_amt,
    input  logic             dsp_en,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_acc,
    input  logic [REG_W-1:0] ld_hi,
    input  logic [REG_W-1:0] ld_lo,
    input  logic [IDX_W-1:0] rd_acc,
    output logic [REG_W-1:0] rd_hi,
    output logic [REG_W-1:0] rd_lo,
    output logic             fault
);
    acc_pair_t        src;
    acc_pair_t        wb;
    logic [REG_W-1:0] joined;
    logic [REG_W-1:0] shifted;
    logic             dir_left;
    logic [AMT_W-1:0] mag;
    logic             do_write;
    logic             fault_q;

    // Accepted operation: strobe with the unit enabled.
    always_comb do_write = op_valid && dsp_en;

    acc_amt_decode #(.AMT_W(AMT_W)) u_dec (
        .amt      (op_amt),
        .dir_left (dir_left),
        .mag      (mag)
    );

    acc_regfile #(.NUM(NUM_ACC), .W(REG_W)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .sh_we   (do_write),
        .sh_idx  (op_acc),
        .sh_hi   (wb.hi),
        .sh_lo   (wb.lo),
        .ld_we   (ld_en),
        .ld_idx  (ld_acc),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .src_idx (op_acc),
        .src_hi  (src.hi),
        .src_lo  (src.lo),
        .rd_idx  (rd_acc),
        .rd_hi   (rd_hi),
        .rd_lo   (rd_lo)
    );

    // Form the 64-bit operand from the low half of each register.
    always_comb joined = {src.hi[HALF_W-1:0], src.lo[HALF_W-1:0]};

    acc_barrel #(.W(REG_W), .SH_W(AMT_W)) u_shift (
        .din      (joined),
        .dir_left (dir_left),
        .mag      (mag),
        .dout     (shifted)
    );

    // Widen each half of the result by its own top bit.
    always_comb begin
        wb.hi = {{HALF_W{shifted[REG_W-1]}},  shifted[REG_W-1:HALF_W]};
        wb.lo = {{HALF_W{shifted[HALF_W-1]}}, shifted[HALF_W-1:0]};
    end

    // Register the disabled-unit fault for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= op_valid && !dsp_en;
    end

    assign fault = fault_q;
endmodule

// File: rtl/acc_shift_chk.sv
`timescale 1ns/1ps
// Module: acc_shift_chk
// Property checker for acc_shift_top, attached with bind. It sees only the
// top-level ports.
module acc_shift_chk
    import acc_shift_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [IDX_W-1:0] op_acc,
    input logic [AMT_W-1:0] op_amt,
    input logic             dsp_en,
    input logic             ld_en,
    input logic [IDX_W-1:0] rd_acc,
    input logic [REG_W-1:0] rd_hi,
    input logic [REG_W-1:0] rd_lo,
    input logic             fault
);
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(op_valid && !dsp_en)); // R8
    AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dsp_en) |=> fault); // R8
    AST_HI_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid && dsp_en) && rd_acc == $past(op_acc))
        |-> rd_hi[REG_W-1:HALF_W] == {HALF_W{rd_hi[HALF_W-1]}}); // R5
    AST_LO_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid && dsp_en) && rd_acc == $past(op_acc))
        |-> rd_lo[REG_W-1:HALF_W] == {HALF_W{rd_lo[HALF_W-1]}}); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!op_valid && !ld_en) && $stable(rd_acc))
        |-> ($stable(rd_hi) && $stable(rd_lo))); // R9
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid && !dsp_en && !ld_en) && $stable(rd_acc))
        |-> ($stable(rd_hi) && $stable(rd_lo))); // R8
    AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid && dsp_en && op_amt == '0 && rd_acc == op_acc)
         && $stable(rd_acc))
        |-> (rd_hi[HALF_W-1:0] == $past(rd_hi[HALF_W-1:0])
             && rd_lo[HALF_W-1:0] == $past(rd_lo[HALF_W-1:0]))); // R4
endmodule

bind acc_shift_top acc_shift_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_acc   (op_acc),
    .op_amt   (op_amt),
    .dsp_en   (dsp_en),
    .ld_en    (ld_en),
    .rd_acc   (rd_acc),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .fault    (fault)
);

// File: tb/test_acc_shift_top.sv
`timescale 1ns/1ps
// Scoreboard bench. Driver tasks apply one operation per cycle, update a
// reference model of the file and queue the expected state of all four
// accumulators. A monitor pops and compares those items at the falling edge.
module test_acc_shift_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_acc = '0;
    logic [5:0]  op_amt = '0;
    logic        dsp_en = 1'b1;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_acc = '0;
    logic [63:0] ld_hi = '0;
    logic [63:0] ld_lo = '0;
    logic [1:0]  rd_acc = '0;
    logic [63:0] rd_hi;
    logic [63:0] rd_lo;
    logic        fault;

    typedef struct {
        logic [1:0]  acc;
        logic [63:0] hi;
        logic [63:0] lo;
        logic        flt;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [63:0] m_hi [4];
    logic [63:0] m_lo [4];
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    acc_shift_top i_acc_shift_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_acc(op_acc),
        .op_amt(op_amt), .dsp_en(dsp_en), .ld_en(ld_en), .ld_acc(ld_acc),
        .ld_hi(ld_hi), .ld_lo(ld_lo), .rd_acc(rd_acc), .rd_hi(rd_hi),
        .rd_lo(rd_lo), .fault(fault)
    );

    // Queue the expected state of every accumulator (R7: others untouched).
    task automatic push_all(input logic flt, input string tag);
        for (int a = 0; a < 4; a++) begin
            item_t it;
            it.acc = 2'(a); it.hi = m_hi[a]; it.lo = m_lo[a];
            it.flt = flt;   it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    // Finish one driven cycle: wait for the edge, release the strobes.
    task automatic close_cycle();
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        ld_en    = 1'b0;
    endtask

    task automatic do_load(input logic [1:0] a, input logic [63:0] h,
                           input logic [63:0] l, input string tag);
        @(negedge clk);
        ld_en = 1'b1; ld_acc = a; ld_hi = h; ld_lo = l;
        close_cycle();
        m_hi[a] = h; m_lo[a] = l;
        push_all(1'b0, tag);
    endtask

    task automatic do_shift(input logic [1:0] a, input logic [5:0] amt,
                            input logic en, input string tag);
        logic [63:0] v;
        logic [63:0] r;
        int          n;
        @(negedge clk);
        op_valid = 1'b1; op_acc = a; op_amt = amt; dsp_en = en;
        close_cycle();
        dsp_en = 1'b1;
        if (en) begin
            v = {m_hi[a][31:0], m_lo[a][31:0]};
            if (!amt[5]) r = v >> int'(amt);
            else begin
                n = 64 - int'(amt);
                r = v << n;
            end
            m_hi[a] = {{32{r[63]}}, r[63:32]};
            m_lo[a] = {{32{r[31]}}, r[31:0]};
        end
        push_all(!en, tag);
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        close_cycle();
        push_all(1'b0, tag);
    endtask

    // Monitor: compare queued items against the read port and fault.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                rd_acc = it.acc;
                #0.5;
                checks++;
                if (rd_hi !== it.hi || rd_lo !== it.lo || fault !== it.flt) begin
                    fails++;
                    $display("FAIL %s acc=%0d: hi=%h lo=%h fault=%b expected hi=%h lo=%h fault=%b",
                             it.tag, it.acc, rd_hi, rd_lo, fault, it.hi, it.lo, it.flt);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        for (int a = 0; a < 4; a++) begin
            m_hi[a] = '0;
            m_lo[a] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        do_idle("R1 reset state");
        do_load(2'd1, 64'hAAAA_5555_8123_4567, 64'h0000_0000_89AB_CDEF, "R11 load");
        do_load(2'd2, 64'h0F0F_0F0F_7FFF_0001, 64'hFFFF_FFFF_0000_8000, "R11 load");
        do_shift(2'd1, 6'd1,  1'b1, "R2 right by 1, R5 hi from bit 63");
        do_shift(2'd1, 6'd31, 1'b1, "R2 right by 31");
        do_load(2'd0, 64'h1234_0000_8000_0001, 64'h0000_0000_F000_000F, "R11 load");
        do_shift(2'd0, 6'd13, 1'b1, "R2 right by 13, R6 lo from bit 31");
        do_shift(2'd2, 6'h3F, 1'b1, "R3 left by 1");
        do_shift(2'd2, 6'h39, 1'b1, "R3 left by 7");
        do_load(2'd3, 64'hDEAD_BEEF_0123_4567, 64'h1111_2222_89AB_CDEF, "R11 load");
        do_shift(2'd3, 6'h20, 1'b1, "R3 left by 32, R6 lo zero");
        do_load(2'd3, 64'hFFFF_0000_0000_0001, 64'h0000_0000_8000_0000, "R11 load");
        do_shift(2'd3, 6'd0,  1'b1, "R4 zero amount, R5 upper bits ignored");
        do_shift(2'd1, 6'h3C, 1'b0, "R8 disabled op");
        do_idle("R8 fault one cycle, R9 idle");
        do_load(2'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0000, "R11 load");
        do_shift(2'd0, 6'h21, 1'b1, "R3 left by 31, R5 and R6");
        do_shift(2'd0, 6'd0,  1'b0, "R8 disabled zero shift");
        do_shift(2'd2, 6'd16, 1'b1, "R2 right by 16, R10 read");
        do_idle("R9 idle hold");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule